// File: doc/BRIEF.md
# Sparsifying Token-Ring Channel Readout

This block drains many per-channel hit FIFOs onto one shared output bus. A token moves around the ring of channels. A channel with an empty FIFO is passed over in the same clock, so no bus cycle is spent on it. The channel that takes the token pops exactly one entry. Its time stamp and its own channel number leave on the bus one clock later, both Gray coded and marked valid. The token then moves to the position just after that channel, so each channel sends at most one entry per visit of the token. A channel that fires all the time therefore gets no more than a 1/n share of the bus. In any clock with nothing to send, the bus carries a fixed idle word with the valid flag low.

The token is held as a one-hot position register. A watchdog re-injects the token at channel 0 if that register ever stops being one-hot for a full window. Two saturating diagnostic counters record token-loss events and cycles in which any channel reports a FIFO overflow. A single clear input resets both counters. The pop strobes are combinational from the not-empty flags, so a FIFO advances on the same edge that captures its head into the output register.

Top module: `token_readout`

## Requirements
- R1: After reset, valid_o is 0, word_o is the idle word (all ones), both counters are 0, and the first search starts at channel 0.
- R2: pop_o has at most one bit set in any cycle, and never a bit whose ne_i is low.
- R3: The popped channel is the first non-empty channel at or after the position just past the previous holder, and the search wraps from the highest channel to channel 0.
- R4: In every cycle where at least one ne_i bit is high, exactly one pop is issued in that same cycle, so empty channels cost no cycle.
- R5: One cycle after a pop of channel c, valid_o is 1 and word_o is {gray(ts), gray(c)}, where ts is that channel's head time stamp, gray(x) = x ^ (x >> 1), the time stamp takes the upper TS_W bits and the channel number the lower CH_W bits.
- R6: One cycle after a cycle with no pop, valid_o is 0 and word_o equals the all-ones idle word.
- R7: When every channel stays non-empty, pops visit the channels in strictly increasing cyclic order, one entry each, so each channel gets one cycle in every NUM_CH.
- R8: ovf_cnt_o rises by exactly one for each cycle in which any ovf_i bit is high, and holds at 255.
- R9: cnt_clr_i clears both counters on the next edge and takes priority over a simultaneous increment.
- R10: The token-loss counter increments only when the token register has been invalid for WDOG_CYC cycles, after which the token restarts at channel 0; in normal operation it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| ne_i | input | NUM_CH | Per-channel FIFO not-empty flags |
| head_ts_i | input | NUM_CH*TS_W | Head time stamp of each channel FIFO, channel c at bits [c*TS_W +: TS_W] |
| ovf_i | input | NUM_CH | Per-channel FIFO overflow pulses |
| cnt_clr_i | input | 1 | Synchronous clear of both diagnostic counters |
| pop_o | output | NUM_CH | One-hot pop strobe to the channel holding the token |
| word_o | output | TS_W+CH_W | Output word: Gray time stamp above Gray channel number, or idle word |
| valid_o | output | 1 | Marks word_o as carrying a real hit |
| lost_cnt_o | output | CNT_W | Saturating count of token-loss recoveries |
| ovf_cnt_o | output | CNT_W | Saturating count of cycles with any overflow |

## Verification
Two sparse directed cases come first. Two isolated channels far apart show that the gap is crossed in one cycle, and a pair that straddles the top channel exercises the wrap. A fully loaded ring, three entries per channel, separates a true one-entry-per-visit rotation from a design that lets a busy channel keep the token. Random traffic at low, medium and high fill densities, with occasional overflow pulses and clears, is compared cycle by cycle against a bench model of the FIFOs and the search pointer. That comparison catches errors in the start position, in the Gray coding and in the idle word. A long burst of overflow pulses followed by a clear that coincides with one more pulse checks saturation and clear priority.

// File: rtl/token_readout_pkg.sv
package token_readout_pkg;

  // Binary-to-Gray conversion on a 32-bit carrier; callers truncate.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/tr_sat_cnt.sv
module tr_sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
    end else if (inc_i && (cnt_o != MAX_VAL)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/tr_arbiter.sv
module tr_arbiter #(
  parameter int NUM_CH   = 128,
  parameter int WDOG_CYC = 128,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WD_W    = $clog2(WDOG_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] grant_o,
  output logic              grant_vld_o,
  output logic [CH_W-1:0]   grant_idx_o,
  output logic              lost_o
);

  localparam logic [NUM_CH-1:0] TOK_HOME = {{(NUM_CH-1){1'b0}}, 1'b1};
  localparam logic [CH_W:0]     RING_LEN = (CH_W+1)'(NUM_CH);
  localparam logic [CH_W-1:0]   LAST_CH  = CH_W'(NUM_CH - 1);

  logic [NUM_CH-1:0] tok_q, tok_d;
  logic [WD_W-1:0]   wd_q, wd_d;
  logic              tok_ok;
  logic [CH_W-1:0]   start_idx;
  logic [CH_W-1:0]   sel_idx;
  logic [CH_W-1:0]   nxt_idx;
  logic [CH_W:0]     pos;
  logic              found;

  assign tok_ok = $onehot(tok_q);

  // Position where the search begins (the token cell).
  always_comb begin
    start_idx = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (tok_q[k]) start_idx = CH_W'(k);
    end
  end

  // Rotating search: first requester at or after start_idx, wrapping.
  always_comb begin
    found   = 1'b0;
    sel_idx = '0;
    pos     = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      pos = {1'b0, start_idx} + (CH_W+1)'(k);
      if (pos >= RING_LEN) pos = pos - RING_LEN;
      if (!found && req_i[pos[CH_W-1:0]]) begin
        found   = 1'b1;
        sel_idx = pos[CH_W-1:0];
      end
    end
  end

  assign nxt_idx = (sel_idx == LAST_CH) ? '0 : sel_idx + 1'b1;

  always_comb begin
    grant_o = '0;
    if (tok_ok && found) grant_o[sel_idx] = 1'b1;
  end

  assign grant_vld_o = tok_ok && found;
  assign grant_idx_o = sel_idx;

  // Token advance and loss recovery.
  always_comb begin
    tok_d  = tok_q;
    wd_d   = '0;
    lost_o = 1'b0;
    if (tok_ok) begin
      if (found) begin
        tok_d          = '0;
        tok_d[nxt_idx] = 1'b1;
      end
    end else if (wd_q == WD_W'(WDOG_CYC - 1)) begin
      tok_d  = TOK_HOME;
      lost_o = 1'b1;
    end else begin
      wd_d = wd_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tok_q <= TOK_HOME;
      wd_q  <= '0;
    end else begin
      tok_q <= tok_d;
      wd_q  <= wd_d;
    end
  end

endmodule

// File: rtl/tr_word_reg.sv
module tr_word_reg
  import token_readout_pkg::*;
#(
  parameter int NUM_CH  = 128,
  parameter int TS_W    = 12,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WORD_W = TS_W + CH_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic [CH_W-1:0]        idx_i,
  input  logic [NUM_CH*TS_W-1:0] ts_flat_i,
  output logic                   valid_o,
  output logic [WORD_W-1:0]      word_o
);

  localparam logic [WORD_W-1:0] IDLE_WORD = {WORD_W{1'b1}};

  logic [TS_W-1:0]   ts_sel;
  logic [WORD_W-1:0] hit_word;

  assign ts_sel   = ts_flat_i[idx_i*TS_W +: TS_W];
  assign hit_word = {TS_W'(bin2gray(32'(ts_sel))), CH_W'(bin2gray(32'(idx_i)))};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      word_o  <= IDLE_WORD;
    end else if (load_i) begin
      valid_o <= 1'b1;
      word_o  <= hit_word;
    end else begin
      valid_o <= 1'b0;
      word_o  <= IDLE_WORD;
    end
  end

endmodule

// File: rtl/token_readout.sv
module token_readout #(
  parameter int NUM_CH   = 128,
  parameter int TS_W     = 12,
  parameter int CNT_W    = 8,
  parameter int WDOG_CYC = 128,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WORD_W  = TS_W + CH_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CH-1:0]      ne_i,
  input  logic [NUM_CH*TS_W-1:0] head_ts_i,
  input  logic [NUM_CH-1:0]      ovf_i,
  input  logic                   cnt_clr_i,
  output logic [NUM_CH-1:0]      pop_o,
  output logic [WORD_W-1:0]      word_o,
  output logic                   valid_o,
  output logic [CNT_W-1:0]       lost_cnt_o,
  output logic [CNT_W-1:0]       ovf_cnt_o
);

  logic            grant_vld;
  logic [CH_W-1:0] grant_idx;
  logic            lost_evt;

  tr_arbiter #(
    .NUM_CH   (NUM_CH),
    .WDOG_CYC (WDOG_CYC)
  ) u_arb (
    .clk         (clk),
    .rst         (rst),
    .req_i       (ne_i),
    .grant_o     (pop_o),
    .grant_vld_o (grant_vld),
    .grant_idx_o (grant_idx),
    .lost_o      (lost_evt)
  );

  tr_word_reg #(
    .NUM_CH (NUM_CH),
    .TS_W   (TS_W)
  ) u_word (
    .clk       (clk),
    .rst       (rst),
    .load_i    (grant_vld),
    .idx_i     (grant_idx),
    .ts_flat_i (head_ts_i),
    .valid_o   (valid_o),
    .word_o    (word_o)
  );

  tr_sat_cnt #(.CNT_W(CNT_W)) u_lost_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (cnt_clr_i),
    .inc_i (lost_evt),
    .cnt_o (lost_cnt_o)
  );

  tr_sat_cnt #(.CNT_W(CNT_W)) u_ovf_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (cnt_clr_i),
    .inc_i (|ovf_i),
    .cnt_o (ovf_cnt_o)
  );

endmodule

// File: rtl/tr_checker.sv
module tr_checker #(
  parameter int NUM_CH = 128,
  parameter int WORD_W = 19,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ne_i,
  input logic [NUM_CH-1:0] ovf_i,
  input logic              cnt_clr_i,
  input logic [NUM_CH-1:0] pop_o,
  input logic [WORD_W-1:0] word_o,
  input logic              valid_o,
  input logic [CNT_W-1:0]  lost_cnt_o,
  input logic [CNT_W-1:0]  ovf_cnt_o
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  p_pop_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop_o));

  p_pop_needs_data_r2: assert property (@(posedge clk) disable iff (rst)
    (pop_o & ~ne_i) == '0);

  p_no_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (|ne_i) |-> (|pop_o));

  p_valid_after_pop_r5: assert property (@(posedge clk) disable iff (rst)
    (|pop_o) |=> valid_o);

  p_idle_word_r6: assert property (@(posedge clk) disable iff (rst)
    !(|pop_o) |=> (!valid_o && word_o == {WORD_W{1'b1}}));

  p_ovf_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr_i && (|ovf_i) && ovf_cnt_o != CMAX) |=> ovf_cnt_o == $past(ovf_cnt_o) + 1'b1);

  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_cnt_o == CMAX && !cnt_clr_i) |=> ovf_cnt_o == CMAX);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_clr_i |=> (ovf_cnt_o == '0 && lost_cnt_o == '0));

  p_no_loss_r10: assert property (@(posedge clk) disable iff (rst)
    lost_cnt_o == '0);

endmodule

bind token_readout tr_checker #(
  .NUM_CH (NUM_CH),
  .WORD_W (WORD_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ne_i       (ne_i),
  .ovf_i      (ovf_i),
  .cnt_clr_i  (cnt_clr_i),
  .pop_o      (pop_o),
  .word_o     (word_o),
  .valid_o    (valid_o),
  .lost_cnt_o (lost_cnt_o),
  .ovf_cnt_o  (ovf_cnt_o)
);

// File: tb/token_readout_tb.sv
module token_readout_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 128;
  localparam int TS_W       = 12;
  localparam int CH_W       = 7;
  localparam int W          = TS_W + CH_W;
  localparam int CNT_W      = 8;
  localparam int DEPTH      = 6;

  logic                   clk = 1'b0;
  logic                   rst;
  logic [NUM_CH-1:0]      ne_i;
  logic [NUM_CH*TS_W-1:0] head_ts_i;
  logic [NUM_CH-1:0]      ovf_i;
  logic                   cnt_clr_i;
  logic [NUM_CH-1:0]      pop_o;
  logic [W-1:0]           word_o;
  logic                   valid_o;
  logic [CNT_W-1:0]       lost_cnt_o;
  logic [CNT_W-1:0]       ovf_cnt_o;

  token_readout u_dut (
    .clk        (clk),
    .rst        (rst),
    .ne_i       (ne_i),
    .head_ts_i  (head_ts_i),
    .ovf_i      (ovf_i),
    .cnt_clr_i  (cnt_clr_i),
    .pop_o      (pop_o),
    .word_o     (word_o),
    .valid_o    (valid_o),
    .lost_cnt_o (lost_cnt_o),
    .ovf_cnt_o  (ovf_cnt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [TS_W-1:0] fmem [NUM_CH][DEPTH];
  int              fcnt [NUM_CH];
  int              start_m = 0;
  int              exp_ovf = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [TS_W-1:0] g_ts(input logic [TS_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CH_W-1:0] g_ch(input int c);
    logic [CH_W-1:0] b;
    b = CH_W'(c);
    return b ^ (b >> 1);
  endfunction

  task automatic drive();
    for (int c = 0; c < NUM_CH; c++) begin
      ne_i[c] = (fcnt[c] > 0);
      head_ts_i[c*TS_W +: TS_W] = (fcnt[c] > 0) ? fmem[c][0] : '0;
    end
  endtask

  task automatic load(input int c, input logic [TS_W-1:0] v);
    if (fcnt[c] < DEPTH) begin
      fmem[c][fcnt[c]] = v;
      fcnt[c]++;
    end
  endtask

  // One readout cycle: called at a falling edge, returns at the next one.
  task automatic step(input bit clr, input logic [NUM_CH-1:0] ov, input int push_pct, output int gidx);
    bit              fnd;
    logic [NUM_CH-1:0] ep;
    logic [W-1:0]    ew;
    for (int c = 0; c < NUM_CH; c++) begin
      if (push_pct > 0 && int'($urandom % 100) < push_pct) load(c, TS_W'($urandom));
    end
    drive();
    ovf_i     = ov;
    cnt_clr_i = clr;
    #1;
    fnd  = 1'b0;
    gidx = -1;
    for (int k = 0; k < NUM_CH; k++) begin
      int c;
      c = (start_m + k) % NUM_CH;
      if (!fnd && fcnt[c] > 0) begin
        fnd  = 1'b1;
        gidx = c;
      end
    end
    ep = '0;
    if (fnd) ep[gidx] = 1'b1;
    chk(pop_o == ep, "R2 R4 pop strobe", pop_o, ep);
    ew = {W{1'b1}};
    if (fnd) ew = {g_ts(fmem[gidx][0]), g_ch(gidx)};
    @(posedge clk);
    #1;
    chk(valid_o == fnd, "R5 valid flag", valid_o, fnd);
    chk(word_o == ew, fnd ? "R5 hit word" : "R6 idle word", word_o, ew);
    if (clr) exp_ovf = 0;
    else if ((|ov) && exp_ovf < 255) exp_ovf++;
    chk(ovf_cnt_o == CNT_W'(exp_ovf), "R8 overflow count", ovf_cnt_o, exp_ovf);
    chk(lost_cnt_o == '0, "R10 token loss count", lost_cnt_o, 0);
    if (fnd) begin
      for (int d = 0; d < DEPTH - 1; d++) fmem[gidx][d] = fmem[gidx][d+1];
      fcnt[gidx]--;
      start_m = (gidx + 1) % NUM_CH;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int g;
    int first;
    logic [NUM_CH-1:0] v;
    void'($urandom(32'd4242));
    for (int c = 0; c < NUM_CH; c++) fcnt[c] = 0;
    rst = 1'b1;
    ne_i = '0;
    head_ts_i = '0;
    ovf_i = '0;
    cnt_clr_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(valid_o == 1'b0, "R1 valid after reset", valid_o, 0);
    chk(word_o == {W{1'b1}}, "R1 idle word after reset", word_o, {W{1'b1}});
    chk(ovf_cnt_o == '0 && lost_cnt_o == '0, "R1 counters after reset", {ovf_cnt_o, lost_cnt_o}, 0);
    chk(pop_o == '0, "R1 no pop after reset", pop_o, 0);
    rst = 1'b0;

    // R1/R4: first search from channel 0, gap crossed in one cycle
    load(5, 12'h0A5);
    load(100, 12'h7C3);
    step(1'b0, '0, 0, g);
    chk(g == 5, "R1 first holder", g, 5);
    step(1'b0, '0, 0, g);
    chk(g == 100, "R4 skip to next data", g, 100);
    step(1'b0, '0, 0, g);
    chk(g == -1, "R6 no data", g, -1);

    // R3: wrap from top channel back to low channels
    load(2, 12'h111);
    load(127, 12'h222);
    step(1'b0, '0, 0, g);
    chk(g == 127, "R3 search from last position", g, 127);
    step(1'b0, '0, 0, g);
    chk(g == 2, "R3 wrap to low channel", g, 2);

    // R7: full ring, one entry per visit
    for (int c = 0; c < NUM_CH; c++) begin
      for (int d = 0; d < 3; d++) load(c, TS_W'($urandom));
    end
    first = start_m;
    for (int i = 0; i < 3 * NUM_CH; i++) begin
      step(1'b0, '0, 0, g);
      chk(g == (first + i) % NUM_CH, "R7 fair rotation", g, (first + i) % NUM_CH);
    end
    step(1'b0, '0, 0, g);
    chk(g == -1, "R7 ring drained", g, -1);

    // Random traffic at several densities
    for (int ph = 0; ph < 8; ph++) begin
      int pct;
      case (ph % 4)
        0: pct = 2;
        1: pct = 10;
        2: pct = 40;
        default: pct = 90;
      endcase
      for (int i = 0; i < 500; i++) begin
        v = '0;
        if ($urandom % 20 == 0) v[$urandom % NUM_CH] = 1'b1;
        step(($urandom % 100) == 0, v, pct, g);
      end
    end

    // R8/R9: saturation and clear priority
    step(1'b1, '0, 0, g);
    for (int i = 0; i < 300; i++) step(1'b0, {NUM_CH{1'b1}}, 0, g);
    chk(ovf_cnt_o == 8'hFF, "R8 saturated", ovf_cnt_o, 8'hFF);
    step(1'b1, {NUM_CH{1'b1}}, 0, g);
    chk(ovf_cnt_o == 8'h00, "R9 clear beats increment", ovf_cnt_o, 0);
    chk(lost_cnt_o == 8'h00, "R10 no token loss", lost_cnt_o, 0);

    finish_run();
  end

endmodule